// File: doc/BRIEF.md
# Aligned Data Access Address Unit

This unit sits between a processor's execute stage and a 32-bit big-endian data bus. For each load or store it builds the effective address and the byte-lane enables, and places the write data on the lanes that the address selects. On a load it takes the returned bytes and extends them to a full word. The address comes from one of two sources. One is a computed sum of a base and an offset. The other is a short direct operand that is scaled by the access size, so that it reaches the low region of the address space. Misaligned half-word and word addresses are rounded down without an exception. The rounding is applied only to the final address.

The unit registers each accepted access and holds it on the memory side until the memory acknowledges it. In the acknowledge cycle it can already accept the next access, so a stream of accesses needs no idle cycle between them. A separate combinational path gives the instruction side an even fetch address.

Top module: `dacc_addr_unit`

## Requirements
- R1: With the computed source, the address is base + offset (modulo 2^32). A word access then clears bits 1:0 and a half-word access clears bit 0; a byte access keeps every bit. The rounding acts on the sum only, so base 1 + offset 1 as a half-word gives address 2.
- R2: A direct byte access presents the 8-bit operand unchanged as address bits 7:0, with every higher bit zero.
- R3: A direct half-word access presents the operand times two as address bits 8:0, with every higher bit zero.
- R4: A direct word access presents the operand times four as address bits 9:0, with every higher bit zero.
- R5: The size code is 00 for byte, 01 for half-word and 10 for word. Code 11 behaves as word.
- R6: Lane enable bit 3 covers data bits 31:24 and address offset 0, down to bit 0 for bits 7:0 and offset 3. A byte access enables exactly the lane of its offset. A half-word enables 1100 at offset 0 and 0011 at offset 2. A word enables 1111.
- R7: Store data is taken from the low bits of the write input: bits 7:0 for a byte, 15:0 for a half-word and all 32 bits for a word. It is placed on the enabled lanes with the more significant byte at the lower address. Lanes that are not enabled carry zero.
- R8: Load data is taken from the enabled lanes and right-justified. When the signed input was high at acceptance, a byte or half-word is sign-extended; otherwise it is zero-extended. A word is returned unchanged whatever the signed input.
- R9: An access is accepted on a rising edge where req_valid and req_ready are both high. From the next cycle mem_req is high. mem_addr, mem_be, mem_we and mem_wdata then hold steady until an edge that sees mem_ack. req_ready is high when mem_req is low or mem_ack is high, so a new access may be accepted on the acknowledging edge.
- R10: After each edge that sees mem_ack with mem_req high, rsp_valid is high for one cycle. For a load, rsp_rdata carries the R8 value; for a store it carries zero. mem_ack while mem_req is low has no effect.
- R11: fetch_addr equals fetch_target with bit 0 cleared, in the same cycle, whatever the data side is doing.
- R12: After reset, mem_req and rsp_valid are low, rsp_rdata is zero and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request from the core |
| req_ready | output | 1 | Unit can accept an access this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (R5) |
| req_direct | input | 1 | 1 = use the scaled direct operand, 0 = use base + offset |
| req_base | input | 32 | Base term of the computed address |
| req_offset | input | 32 | Offset term of the computed address |
| req_dir_op | input | 8 | Direct address operand |
| req_wdata | input | 32 | Right-justified store data |
| req_signed | input | 1 | Sign-extend narrow loads |
| mem_req | output | 1 | Access pending toward memory |
| mem_we | output | 1 | Pending access is a store |
| mem_addr | output | 32 | Aligned effective address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_ack | input | 1 | Memory completes the pending access |
| mem_rdata | input | 32 | Load data from memory, valid with mem_ack |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Extended load result |
| fetch_target | input | 32 | Computed instruction address |
| fetch_addr | output | 32 | Even instruction fetch address |

## Verification
The case of most interest is an edge that completes one access and accepts the next. On that edge the response path reads the stored context of the old access while the request registers load the new one. The bench provokes this by raising the next request in the same cycle as mem_ack, with the two accesses differing in size, lane offset and direction. It then checks, in the following cycle, both the response of the first access and the address, enables and data of the second. Random transactions mix acknowledge delays of zero to three cycles with random sizes, sources and offsets. Directed cases cover the odd sums that become aligned only after the addition, and the largest direct operand at each size.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WALT = 2'b11
   } dacc_size_e;

   // log2 of the access width in bytes; the spare code folds onto word
   function automatic logic [1:0] size_log2(dacc_size_e s);
      case (s)
         SZ_BYTE: size_log2 = 2'd0;
         SZ_HALF: size_log2 = 2'd1;
         default: size_log2 = 2'd2;
      endcase
   endfunction

   // context kept with a pending access for the response path
   typedef struct packed {
      logic       we;
      logic [1:0] lanelo;
      logic [1:0] szl;
      logic       sgn;
   } dacc_ctx_t;

endpackage

// File: rtl/dacc_ea_gen.sv
module dacc_ea_gen #(
   parameter int ADDR_W = 32,
   parameter int DIR_W  = 8
) (
   input  logic              direct,
   input  logic [1:0]        szl,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   input  logic [DIR_W-1:0]  dir_op,
   output logic [ADDR_W-1:0] ea
);
   localparam int PAD_W = ADDR_W - DIR_W;

   generate
      if (PAD_W < 2) begin : g_bad_width
         $error("dacc_ea_gen: ADDR_W must exceed DIR_W by at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] dir_scaled;
   logic [ADDR_W-1:0] raw;
   logic [ADDR_W-1:0] low_mask;

   always_comb begin
      // full-width sum first; rounding happens only on the result
      sum        = base + offset;
      dir_scaled = {{PAD_W{1'b0}}, dir_op} << szl;
      raw        = direct ? dir_scaled : sum;
      low_mask   = ({{(ADDR_W-1){1'b0}}, 1'b1} << szl) - {{(ADDR_W-1){1'b0}}, 1'b1};
      ea         = raw & ~low_mask;
   end

endmodule

// File: rtl/dacc_lane_steer.sv
module dacc_lane_steer #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        szl,
   input  logic [1:0]        off,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [1:0]        lanelo,
   output logic [3:0]        be,
   output logic [DATA_W-1:0] wdata_out
);
   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("dacc_lane_steer: only a 32-bit bus is supported");
      end
   endgenerate

   logic [2:0]        nbytes;
   logic [2:0]        lo3;
   logic [DATA_W-1:0] shifted;

   always_comb begin
      nbytes  = 3'd1 << szl;
      // big-endian: offset 0 is the top lane, so the lowest lane used
      // is the distance from the access end to the bus end
      lo3     = 3'(LANES) - nbytes - {1'b0, off};
      lanelo  = lo3[1:0];
      shifted = wdata_in << {lanelo, 3'b000};
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [2:0] KI = 3'(k);
      assign be[k] = (KI >= {1'b0, lanelo}) && (KI < ({1'b0, lanelo} + nbytes));
      assign wdata_out[8*k +: 8] = be[k] ? shifted[8*k +: 8] : 8'h00;
   end

endmodule

// File: rtl/dacc_rd_extract.sv
module dacc_rd_extract #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] rdata,
   input  logic [1:0]        lanelo,
   input  logic [1:0]        szl,
   input  logic              sgn,
   input  logic              we,
   output logic [DATA_W-1:0] value
);
   logic [DATA_W-1:0] just;

   always_comb begin
      just = rdata >> {lanelo, 3'b000};
      if (we) begin
         value = '0;
      end else begin
         case (szl)
            2'd0:    value = {{(DATA_W-8){sgn & just[7]}}, just[7:0]};
            2'd1:    value = {{(DATA_W-16){sgn & just[15]}}, just[15:0]};
            default: value = just;
         endcase
      end
   end

endmodule

// File: rtl/dacc_fetch_align.sv
module dacc_fetch_align #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] fetch
);
   assign fetch = {target[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/dacc_addr_unit.sv
module dacc_addr_unit
   import dacc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DIR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic              req_direct,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [DIR_W-1:0]  req_dir_op,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_signed,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic [ADDR_W-1:0] fetch_target,
   output logic [ADDR_W-1:0] fetch_addr
);
   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("dacc_addr_unit: DATA_W must be 32");
      end
      if (ADDR_W < DIR_W + 2) begin : g_bad_addr
         $error("dacc_addr_unit: ADDR_W too small for scaled direct operand");
      end
   endgenerate

   logic [1:0]        szl;
   logic [ADDR_W-1:0] ea;
   logic [1:0]        lanelo;
   logic [3:0]        be_n;
   logic [DATA_W-1:0] wd_n;
   logic [DATA_W-1:0] rd_val;
   logic              accept;
   logic              done;

   dacc_ctx_t         ctx_q;
   logic              req_q;
   logic [ADDR_W-1:0] addr_q;
   logic [3:0]        be_q;
   logic [DATA_W-1:0] wd_q;
   logic              rsp_v_q;
   logic [DATA_W-1:0] rsp_d_q;

   assign szl = size_log2(dacc_size_e'(req_size));

   dacc_ea_gen #(.ADDR_W(ADDR_W), .DIR_W(DIR_W)) u_ea (
      .direct (req_direct),
      .szl    (szl),
      .base   (req_base),
      .offset (req_offset),
      .dir_op (req_dir_op),
      .ea     (ea)
   );

   dacc_lane_steer #(.DATA_W(DATA_W)) u_steer (
      .szl       (szl),
      .off       (ea[1:0]),
      .wdata_in  (req_wdata),
      .lanelo    (lanelo),
      .be        (be_n),
      .wdata_out (wd_n)
   );

   dacc_rd_extract #(.DATA_W(DATA_W)) u_rd (
      .rdata  (mem_rdata),
      .lanelo (ctx_q.lanelo),
      .szl    (ctx_q.szl),
      .sgn    (ctx_q.sgn),
      .we     (ctx_q.we),
      .value  (rd_val)
   );

   dacc_fetch_align #(.ADDR_W(ADDR_W)) u_fetch (
      .target (fetch_target),
      .fetch  (fetch_addr)
   );

   assign done      = req_q & mem_ack;
   assign req_ready = ~req_q | mem_ack;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         addr_q <= '0;
         be_q   <= '0;
         wd_q   <= '0;
         ctx_q  <= '0;
      end else if (accept) begin
         req_q        <= 1'b1;
         addr_q       <= ea;
         be_q         <= be_n;
         wd_q         <= req_write ? wd_n : '0;
         ctx_q.we     <= req_write;
         ctx_q.lanelo <= lanelo;
         ctx_q.szl    <= szl;
         ctx_q.sgn    <= req_signed;
      end else if (done) begin
         req_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
      end else begin
         rsp_v_q <= done;
         if (done) rsp_d_q <= rd_val;
      end
   end

   assign mem_req   = req_q;
   assign mem_we    = ctx_q.we;
   assign mem_addr  = addr_q;
   assign mem_be    = be_q;
   assign mem_wdata = wd_q;
   assign rsp_valid = rsp_v_q;
   assign rsp_rdata = rsp_d_q;

endmodule

// File: rtl/dacc_addr_unit_chk.sv
module dacc_addr_unit_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [3:0]        mem_be,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] fetch_target,
   input logic [ADDR_W-1:0] fetch_addr
);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                 && $stable(mem_we) && $stable(mem_wdata)));

   assert_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(req_valid && req_ready));

   assert_word_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_be == 4'hF) |-> (mem_addr[1:0] == 2'b00));

   assert_half_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && (mem_be == 4'b1100 || mem_be == 4'b0011))
         |-> (mem_addr[0] == 1'b0 && mem_addr[1] == (mem_be == 4'b0011)));

   assert_byte_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $countones(mem_be) == 1) |-> (mem_be == (4'b1000 >> mem_addr[1:0])));

   assert_be_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b1100
                   || mem_be == 4'b0011 || mem_be == 4'hF));

   assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(mem_req && mem_ack));

   always @(posedge clk) begin
      if (rst_n) begin
         assert_fetch_even_R11: assert (fetch_addr[0] == 1'b0
            && fetch_addr[ADDR_W-1:1] == fetch_target[ADDR_W-1:1]);
      end
   end

endmodule

bind dacc_addr_unit dacc_addr_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .mem_req      (mem_req),
   .mem_ack      (mem_ack),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .mem_be       (mem_be),
   .mem_wdata    (mem_wdata),
   .rsp_valid    (rsp_valid),
   .fetch_target (fetch_target),
   .fetch_addr   (fetch_addr)
);

// File: tb/dacc_addr_unit_bench.sv
`timescale 1ns/1ps
module dacc_addr_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_direct = 1'b0;
   logic [31:0] req_base = '0;
   logic [31:0] req_offset = '0;
   logic [7:0]  req_dir_op = '0;
   logic [31:0] req_wdata = '0;
   logic        req_signed = 1'b0;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [31:0] fetch_target = '0;
   logic [31:0] fetch_addr;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   // expected issue values and saved context of the current access
   logic [31:0] e_addr, e_wd;
   logic [3:0]  e_be;
   logic        e_we, e_sgn;
   logic [1:0]  e_size;

   always #10 clk = ~clk;

   dacc_addr_unit u_dacc_addr_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_direct(req_direct),
      .req_base(req_base), .req_offset(req_offset), .req_dir_op(req_dir_op),
      .req_wdata(req_wdata), .req_signed(req_signed), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .fetch_target(fetch_target), .fetch_addr(fetch_addr)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // R5: 00 byte, 01 half, 10 and 11 word
   function automatic logic [31:0] f_ea(logic dir, logic [1:0] sz, logic [31:0] b,
                                        logic [31:0] o, logic [7:0] op);
      logic [31:0] s;
      s = b + o;
      if (dir) begin
         case (sz)
            2'b00:   f_ea = {24'h0, op};
            2'b01:   f_ea = {23'h0, op, 1'b0};
            default: f_ea = {22'h0, op, 2'b00};
         endcase
      end else begin
         case (sz)
            2'b00:   f_ea = s;
            2'b01:   f_ea = {s[31:1], 1'b0};
            default: f_ea = {s[31:2], 2'b00};
         endcase
      end
   endfunction

   function automatic logic [3:0] f_be(logic [1:0] sz, logic [31:0] a);
      case (sz)
         2'b00: case (a[1:0])
                   2'd0: f_be = 4'b1000;
                   2'd1: f_be = 4'b0100;
                   2'd2: f_be = 4'b0010;
                   default: f_be = 4'b0001;
                endcase
         2'b01:   f_be = a[1] ? 4'b0011 : 4'b1100;
         default: f_be = 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] f_wd(logic [1:0] sz, logic [31:0] a, logic [31:0] d);
      case (sz)
         2'b00: case (a[1:0])
                   2'd0: f_wd = {d[7:0], 24'h0};
                   2'd1: f_wd = {8'h0, d[7:0], 16'h0};
                   2'd2: f_wd = {16'h0, d[7:0], 8'h0};
                   default: f_wd = {24'h0, d[7:0]};
                endcase
         2'b01:   f_wd = a[1] ? {16'h0, d[15:0]} : {d[15:0], 16'h0};
         default: f_wd = d;
      endcase
   endfunction

   function automatic logic [31:0] f_rd(logic we, logic [1:0] sz, logic [31:0] a,
                                        logic sg, logic [31:0] r);
      logic [7:0]  b;
      logic [15:0] h;
      case (a[1:0])
         2'd0: b = r[31:24];
         2'd1: b = r[23:16];
         2'd2: b = r[15:8];
         default: b = r[7:0];
      endcase
      h = a[1] ? r[15:0] : r[31:16];
      if (we) f_rd = 32'h0;
      else case (sz)
         2'b00:   f_rd = {{24{sg & b[7]}}, b};
         2'b01:   f_rd = {{16{sg & h[15]}}, h};
         default: f_rd = r;
      endcase
   endfunction

   // drive a request at the current negedge and record expectations
   task automatic drive_req(logic w, logic [1:0] sz, logic dir, logic [31:0] b,
                            logic [31:0] o, logic [7:0] op, logic [31:0] d, logic sg);
      req_valid = 1'b1; req_write = w; req_size = sz; req_direct = dir;
      req_base = b; req_offset = o; req_dir_op = op; req_wdata = d; req_signed = sg;
      e_addr = f_ea(dir, sz, b, o, op);
      e_be   = f_be(sz, e_addr);
      e_wd   = w ? f_wd(sz, e_addr, d) : 32'h0;
      e_we   = w; e_sgn = sg; e_size = sz;
      fetch_target = $urandom;
      #1;
      check("R11 fetch", fetch_addr, {fetch_target[31:1], 1'b0});
      check("R9 ready", {31'h0, req_ready}, 32'h1);
   endtask

   task automatic check_issue(string tag);
      check({tag, " mem_req R9"}, {31'h0, mem_req}, 32'h1);
      check({tag, " addr R1"}, mem_addr, e_addr);
      check({tag, " be R6"}, {28'h0, mem_be}, {28'h0, e_be});
      check({tag, " wdata R7"}, mem_wdata, e_wd);
      check({tag, " we R10"}, {31'h0, mem_we}, {31'h0, e_we});
   endtask

   // one full access with an acknowledge delay of dly cycles
   task automatic txn(logic w, logic [1:0] sz, logic dir, logic [31:0] b, logic [31:0] o,
                      logic [7:0] op, logic [31:0] d, logic sg, int dly);
      logic [31:0] exp_r;
      @(negedge clk);
      check("R10 pulse ends", {31'h0, rsp_valid}, 32'h0);
      drive_req(w, sz, dir, b, o, op, d, sg);
      @(negedge clk);
      req_valid = 1'b0;
      check_issue("issue");
      for (int i = 0; i < dly; i++) begin
         @(negedge clk);
         check_issue("hold");
      end
      mem_ack = 1'b1;
      mem_rdata = $urandom;
      exp_r = f_rd(e_we, e_size, e_addr, e_sgn, mem_rdata);
      @(negedge clk);
      mem_ack = 1'b0;
      check("R10 rsp_valid", {31'h0, rsp_valid}, 32'h1);
      check("R8 rsp_rdata", rsp_rdata, exp_r);
      check("R9 req dropped", {31'h0, mem_req}, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      logic [31:0] exp_r;
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      @(negedge clk);
      // R12 reset state
      check("R12 mem_req", {31'h0, mem_req}, 32'h0);
      check("R12 rsp_valid", {31'h0, rsp_valid}, 32'h0);
      check("R12 rsp_rdata", rsp_rdata, 32'h0);
      check("R12 req_ready", {31'h0, req_ready}, 32'h1);
      rst_n = 1'b1;

      // R1: rounding after the sum
      txn(1'b0, 2'b01, 1'b0, 32'h0000_0001, 32'h0000_0001, 8'h00, 32'h0, 1'b0, 0);
      check("R1 half 1+1", e_addr, 32'h0000_0002);
      txn(1'b1, 2'b10, 1'b0, 32'h0000_1003, 32'h0000_0001, 8'h00, 32'hA1B2C3D4, 1'b0, 1);
      txn(1'b1, 2'b00, 1'b0, 32'h0000_2001, 32'h0000_0002, 8'h00, 32'h0000_00E7, 1'b0, 0);
      // R5: spare size code acts as word
      txn(1'b1, 2'b11, 1'b0, 32'h0000_3007, 32'h0, 8'h00, 32'h1234_5678, 1'b0, 2);
      // R2 R3 R4: largest direct operand per size
      txn(1'b0, 2'b00, 1'b1, 32'hFFFF_FFFF, 32'h1, 8'hFF, 32'h0, 1'b1, 0);
      txn(1'b0, 2'b01, 1'b1, 32'hFFFF_FFFF, 32'h1, 8'hFF, 32'h0, 1'b1, 1);
      txn(1'b1, 2'b10, 1'b1, 32'hFFFF_FFFF, 32'h1, 8'hFF, 32'hCAFE_F00D, 1'b0, 0);
      check("R4 direct word", e_addr, 32'h0000_03FC);
      // R8: signed half at offset 0 with negative data
      @(negedge clk);
      drive_req(1'b0, 2'b01, 1'b0, 32'h0000_4000, 32'h0, 8'h00, 32'h0, 1'b1);
      @(negedge clk);
      req_valid = 1'b0;
      check_issue("R8 setup");
      mem_ack = 1'b1; mem_rdata = 32'h8001_7F00;
      @(negedge clk);
      mem_ack = 1'b0;
      check("R8 signed half", rsp_rdata, 32'hFFFF_8001);

      // R10: stray acknowledge while idle has no effect
      @(negedge clk);
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      check("R10 stray ack rsp", {31'h0, rsp_valid}, 32'h0);
      check("R10 stray ack req", {31'h0, mem_req}, 32'h0);

      // R9 back to back: ack of a load and acceptance of a store on one edge
      @(negedge clk);
      drive_req(1'b0, 2'b00, 1'b0, 32'h0000_5002, 32'h1, 8'h00, 32'h0, 1'b1);
      @(negedge clk);
      req_valid = 1'b0;
      check_issue("b2b first");
      mem_ack = 1'b1; mem_rdata = 32'h1122_33F4;
      exp_r = f_rd(e_we, e_size, e_addr, e_sgn, mem_rdata);
      drive_req(1'b1, 2'b01, 1'b0, 32'h0000_6000, 32'h2, 8'h00, 32'h0000_BEEF, 1'b0);
      @(negedge clk);
      mem_ack = 1'b0; req_valid = 1'b0;
      check("R10 b2b rsp_valid", {31'h0, rsp_valid}, 32'h1);
      check("R8 b2b rsp_rdata", rsp_rdata, exp_r);
      check("R8 b2b signed byte", exp_r, 32'hFFFF_FFF4);
      check_issue("b2b second");
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      check("R10 store rsp zero", rsp_rdata, 32'h0);

      // random mix
      for (int n = 0; n < 400; n++) begin
         txn(1'($urandom), 2'($urandom), 1'($urandom), $urandom, $urandom,
             8'($urandom), $urandom, 1'($urandom), int'($urandom_range(0, 3)));
      end

      summary();
   end

endmodule